// File: doc/BRIEF.md
# Selectable-Rate Timestamp Counter

This block keeps a 32-bit count of elapsed time that runs freely from the core clock. Software picks one of three time bases through a configuration word. The fine base adds a fixed nanosecond step on every core cycle. The two coarse bases add one count per microsecond or per millisecond, and they get their ticks from a shared prescaler. Both the configuration word and the count are reached through plain 32-bit register writes and combinational reads.

A clear bit sits in the same configuration word as the source field, and it works as a level. While it is set, the count is forced to zero. Writing the source field on its own releases the count, and counting resumes from zero at the retained rate. A configuration write that names a source above 2 is dropped as a whole. Every accepted configuration write restarts the prescaler, so a coarse period always begins at a known point.

Top module: `stamp_timer`

## Requirements
- R1: While reset is asserted, the configuration word (address 0) and the count (address 1) both read zero, and the selected source is 0.
- R2: With source 0 selected and the clear bit low, the count grows by FINE_STEP (default 20) on every core clock edge after the one that accepted the configuration write.
- R3: With source 1 selected, the count grows by one on every US_DIV-th edge after the accepting edge (default 50), so that n edges after the write it has grown by floor(n/US_DIV).
- R4: With source 2 selected, the count grows by one on every MS_DIV-th edge after the accepting edge (default 50000), so that n edges after the write it has grown by floor(n/MS_DIV).
- R5: A write to address 0 whose bits 7:0 exceed 2 has no effect. The source, the clear bit, the prescaler phase and the count all continue as if the write had not happened.
- R6: Accepting a write with bit 8 set makes the count zero at that edge and holds it at zero while bit 8 stays set. The write that clears bit 8 leaves the count at zero on its own edge, after which counting resumes at the stored source.
- R7: An accepted configuration write does not change the count on its edge, even when that edge would have been a tick. It does not clear the count unless bit 8 is set, and it restarts the prescaler phase.
- R8: The count wraps modulo 2^32.
- R9: Address 0 reads bit 8 as the clear bit and bits 7:0 as the source, with all other bits zero. Bits 31:9 of a write are ignored.
- R10: Writes to address 1 have no effect on the count. Addresses other than 0 and 1 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register address: 0 is configuration, 1 is count |
| busWrite | input | 1 | Write strobe, sampled on the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |

## Verification
Two events can fall in the same cycle: an accepted configuration write and a prescaler tick. The bench provokes this by writing the same coarse source again exactly on the edge where the running period would end. It then requires that the count keeps its value on that edge and that the next step arrives a full period later. A related case is a rejected write that lands mid-period. Its effect is judged by checking that the original tick schedule continues unshifted.

// File: rtl/stamp_timer_pkg.sv
package stamp_timer_pkg;
  localparam int SRC_W      = 8;
  localparam int CLR_BIT    = 8;
  localparam int MAX_SRC    = 2;
  localparam int DATA_W     = 32;

  typedef enum logic [1:0] {
    SRC_FINE  = 2'd0,
    SRC_MICRO = 2'd1,
    SRC_MILLI = 2'd2
  } stamp_src_e;

  typedef struct packed {
    logic clear;
    logic advance;
    logic fine;
  } stamp_strobe_t;
endpackage

// File: rtl/stamp_prescale.sv
module stamp_prescale #(
  parameter int US_DIV = 50,
  parameter int MS_DIV = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       restart,
  input  logic       holdIdle,
  input  logic [1:0] srcSel,
  output logic       tick
);
  import stamp_timer_pkg::*;

  localparam int MAX_DIV = (MS_DIV > US_DIV) ? MS_DIV : US_DIV;
  localparam int PRE_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
  localparam logic [PRE_W-1:0] US_LIM = PRE_W'(US_DIV - 1);
  localparam logic [PRE_W-1:0] MS_LIM = PRE_W'(MS_DIV - 1);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLim;
  logic             coarseHit;

  always_comb begin
    preLim = (srcSel == SRC_MICRO) ? US_LIM : MS_LIM;
  end

  assign coarseHit = (preCnt == preLim);
  assign tick      = (srcSel == SRC_FINE) ? 1'b1 : coarseHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (restart || holdIdle || srcSel == SRC_FINE || coarseHit) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // R3/R4: the phase counter never exceeds the longest period
  p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= MS_LIM || preCnt <= US_LIM);

  // R7: a restart sends the phase back to zero on the next cycle
  p_restart_phase_r7: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> preCnt == '0);
endmodule

// File: rtl/stamp_ctrl.sv
module stamp_ctrl #(
  parameter int ADDR_W   = 4,
  parameter int US_DIV   = 50,
  parameter int MS_DIV   = 50000,
  parameter int CFG_ADDR = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrite,
  input  logic [31:0]           busWdata,
  output logic [31:0]           cfgWord,
  output stamp_timer_pkg::stamp_strobe_t strobe
);
  import stamp_timer_pkg::*;

  logic [SRC_W-1:0] srcSel;
  logic             holdClr;
  logic             cfgHit;
  logic             cfgAccept;
  logic             tick;

  assign cfgHit    = busWrite && (busAddr == ADDR_W'(CFG_ADDR));
  assign cfgAccept = cfgHit && (busWdata[SRC_W-1:0] <= SRC_W'(MAX_SRC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSel  <= '0;
      holdClr <= 1'b0;
    end else if (cfgAccept) begin
      srcSel  <= busWdata[SRC_W-1:0];
      holdClr <= busWdata[CLR_BIT];
    end
  end

  stamp_prescale #(.US_DIV(US_DIV), .MS_DIV(MS_DIV)) u_prescale (
    .clk      (clk),
    .rstN     (rstN),
    .restart  (cfgAccept),
    .holdIdle (holdClr),
    .srcSel   (srcSel[1:0]),
    .tick     (tick)
  );

  always_comb begin
    strobe.clear   = holdClr || (cfgAccept && busWdata[CLR_BIT]);
    strobe.advance = tick && !cfgAccept && !holdClr;
    strobe.fine    = (srcSel[1:0] == SRC_FINE);
    cfgWord        = '0;
    cfgWord[SRC_W-1:0] = srcSel;
    cfgWord[CLR_BIT]   = holdClr;
  end

  // R5: an out-of-range source leaves the configuration untouched
  p_bad_src_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgHit && busWdata[SRC_W-1:0] > SRC_W'(MAX_SRC)) |=> $stable(cfgWord));

  // R9: the stored source is always one of the three legal values
  p_src_legal_r9: assert property (@(posedge clk) disable iff (!rstN)
    srcSel <= SRC_W'(MAX_SRC));

  // R6: while the clear level is stored, the count is never told to advance
  p_clear_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgWord[CLR_BIT] |-> !strobe.advance);
endmodule

// File: rtl/stamp_count.sv
module stamp_count #(
  parameter int unsigned FINE_STEP = 20
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  stamp_timer_pkg::stamp_strobe_t strobe,
  output logic [31:0]                    count
);
  localparam logic [31:0] FINE_INC   = 32'(FINE_STEP);
  localparam logic [31:0] COARSE_INC = 32'd1;

  logic [31:0] incVal;

  assign incVal = strobe.fine ? FINE_INC : COARSE_INC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.clear) begin
      count <= '0;
    end else if (strobe.advance) begin
      count <= count + incVal;
    end
  end

  // R6: a clear request leaves the count at zero
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> count == '0);

  // R2/R8: fine steps add the fixed nanosecond increment modulo 2^32
  p_fine_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && strobe.fine && !strobe.clear) |=>
      count == $past(count) + FINE_INC);

  // R3: coarse steps add exactly one
  p_coarse_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.fine && !strobe.clear) |=>
      count == $past(count) + 32'd1);

  // R7: with no advance and no clear the count holds
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.clear) |=> $stable(count));
endmodule

// File: rtl/stamp_timer.sv
module stamp_timer #(
  parameter int unsigned FINE_STEP = 20,
  parameter int          US_DIV    = 50,
  parameter int          MS_DIV    = 50000,
  parameter int          ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata
);
  import stamp_timer_pkg::*;

  localparam int CFG_ADDR = 0;
  localparam int CNT_ADDR = 1;

  stamp_strobe_t strobe;
  logic [31:0]   cfgWord;
  logic [31:0]   count;

  stamp_ctrl #(
    .ADDR_W(ADDR_W), .US_DIV(US_DIV), .MS_DIV(MS_DIV), .CFG_ADDR(CFG_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .cfgWord(cfgWord), .strobe(strobe)
  );

  stamp_count #(.FINE_STEP(FINE_STEP)) u_count (
    .clk(clk), .rstN(rstN), .strobe(strobe), .count(count)
  );

  always_comb begin
    if (busAddr == ADDR_W'(CFG_ADDR))      busRdata = cfgWord;
    else if (busAddr == ADDR_W'(CNT_ADDR)) busRdata = count;
    else                                   busRdata = '0;
  end
endmodule

// File: tb/stamp_timer_bench.sv
module stamp_timer_bench;
  localparam int unsigned STEP = 32'h3000_0007;
  localparam int US = 5;
  localparam int MS = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stamp_timer #(.FINE_STEP(STEP), .US_DIV(US), .MS_DIV(MS), .ADDR_W(4)) u_stamp_timer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  function automatic logic [31:0] grow(int src, int n);
    if (src == 0) return 32'(n) * 32'(STEP);
    if (src == 1) return 32'(n / US);
    return 32'(n / MS);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic sweep(string tag, int src, logic [31:0] base, int firstN, int lastN);
    logic [31:0] v;
    for (int n = firstN; n <= lastN; n++) begin
      @(negedge clk);
      readReg(4'd1, v);
      check(tag, v, base + grow(src, n));
    end
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] c0;
    @(negedge clk);
    readReg(4'd0, v); check("R1 cfg in reset", v, 32'h0);
    readReg(4'd1, v); check("R1 count in reset", v, 32'h0);
    readReg(4'd2, v); check("R10 unmapped reads zero", v, 32'h0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 / R8 fine source, wraps quickly with the large bench step
    readReg(4'd1, c0); writeReg(4'd0, 32'h0);
    readReg(4'd1, v); check("R7 no step on write edge", v, c0);
    sweep("R2/R8 fine sweep", 0, c0, 1, 20);

    // R3 micro source
    @(negedge clk);
    readReg(4'd1, c0); writeReg(4'd0, 32'h1);
    readReg(4'd1, v); check("R7 count kept on source change", v, c0);
    readReg(4'd0, v); check("R9 cfg reads source 1", v, 32'h1);
    sweep("R3 micro sweep", 1, c0, 1, 4 * US - 1);

    // R7 write lands on the tick edge: step suppressed, phase restarted
    readReg(4'd1, c0); writeReg(4'd0, 32'h1);
    readReg(4'd1, v); check("R7 tick edge suppressed", v, c0);
    sweep("R7 restarted phase", 1, c0, 1, 12);

    // R5 rejected writes mid-period keep schedule and config
    writeReg(4'd0, 32'h0000_0003);
    readReg(4'd1, v); check("R5 bad source no effect", v, c0 + grow(1, 13));
    readReg(4'd0, v); check("R5 cfg unchanged", v, 32'h1);
    writeReg(4'd0, 32'h0000_01FF);
    readReg(4'd1, v); check("R5 bad source with clear ignored", v, c0 + grow(1, 14));
    readReg(4'd0, v); check("R5 cfg unchanged after clear try", v, 32'h1);
    // R10 count address is read-only
    writeReg(4'd1, 32'h0);
    readReg(4'd1, v); check("R10 count write ignored", v, c0 + grow(1, 15));
    sweep("R10 schedule continues", 1, c0, 16, 22);

    // R4 milli source
    @(negedge clk);
    readReg(4'd1, c0); writeReg(4'd0, 32'h2);
    sweep("R4 milli sweep", 2, c0, 1, 2 * MS + 5);

    // R6 clear level, source retained; R9 readback and upper bits ignored
    writeReg(4'd0, 32'hFFFF_FF02 & 32'hFFFF_FE02 | 32'h0000_0100);
    readReg(4'd1, v); check("R6 cleared on write edge", v, 32'h0);
    readReg(4'd0, v); check("R9 cfg reads clear and source", v, 32'h0000_0102);
    sweep("R6 held at zero", 0, 32'h0, 0, 0);
    repeat (8) begin
      @(negedge clk);
      readReg(4'd1, v); check("R6 hold", v, 32'h0);
    end
    writeReg(4'd0, 32'h2);
    readReg(4'd1, v); check("R6 zero on release edge", v, 32'h0);
    readReg(4'd0, v); check("R6 source kept", v, 32'h2);
    sweep("R6 resume milli", 2, 32'h0, 1, MS + 3);

    writeReg(4'd0, 32'hABCD_E101);
    readReg(4'd0, v); check("R9 upper write bits dropped", v, 32'h0000_0101);
    readReg(4'd1, v); check("R6 clear from micro", v, 32'h0);
    writeReg(4'd0, 32'h0);
    readReg(4'd1, v); check("R6 release to fine", v, 32'h0);
    sweep("R2/R8 fine from zero", 0, 32'h0, 1, 12);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule